// File: doc/BRIEF.md
# Dual-Edge Reduced-Swing Video Line Deserializer

This block turns a nine-lane video bus, clocked on both edges of its data clock, into one line of 384 six-bit column values. The lanes form three groups of three, one group per color. Each group carries a 6-bit color word as two 3-bit halves on consecutive data-clock transitions: the even-numbered bits come first, then the odd-numbered bits. Once both halves of all three colors are in, the block pushes the red/green/blue triplet into a column shift register that holds 128 triplets, which is 384 columns with the colors interleaved.

A rising edge on the line-load input copies the whole shift register into a hold bank. The hold bank drives the output that a converter would consume. The same rising edge also marks the start of a new line, so the half-word pairing starts again on an even half. The data clock and load inputs are single-ended levels. The block samples them with its own clock `clk_i`, which must be fast enough that every data-clock level lasts at least two `clk_i` cycles, and detects both transitions of the data clock there.

Top module: `rsds_line_deser`

## Requirements
- R1: After reset every bit of `line_o` is 0.
- R2: Lane index = color*3 + n. The colors are red=0 (lanes 0-2), green=1 (lanes 3-5) and blue=2 (lanes 6-8). Within a color, lane n=0 is the least significant position and n=2 the most significant.
- R3: A color word is assembled as {o2,e2,o1,e1,o0,e0}, where e_n is lane n on the even half and o_n is lane n on the odd half.
- R4: Every transition of the data clock delivers one half word, rising and falling alike. After a line start the halves alternate even, odd, even, and so on.
- R5: Column j (1..384) appears on `line_o[(j-1)*6 +: 6]`. Red sits on columns with j mod 3 = 1, green on j mod 3 = 2 and blue on j mod 3 = 0. The first triplet of a line lands on columns 1-3 and the 128th on columns 382-384.
- R6: One triplet is shifted in per odd half word. When a line has more than 128 triplets, the oldest are dropped and the register keeps the last 128.
- R7: The hold bank, and with it `line_o`, changes only on a rising edge of `line_load_i`. It captures the shift register as it stood before that edge's cycle. While the load input stays high, or when it falls, the hold bank stays as it is.
- R8: A load rising edge restarts the pairing on an even half. An unpaired even half that was pending is discarded and causes no shift.
- R9: A data-clock transition seen in the same cycle as a load rising edge counts as the even half of the new line. The hold bank still captures the contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dclk_i | input | 1 | Data clock; both transitions carry a half word |
| rsds_data_i | input | 9 | Nine data lanes, color*3 + lane |
| line_load_i | input | 1 | Line load; rising edge transfers the line and restarts pairing |
| line_o | output | 2304 | Held line, column j at bits (j-1)*6 +: 6 |

## Verification
Two events can fall in the same sampled cycle: a data-clock transition and a load rising edge. When they coincide, the load captures the old line while the pairing logic has to treat the transition as the first even half of the next line. The bench provokes this by toggling the data clock and raising the load at the same instant, with the even half of the new line's first pixel already on the lanes. It then judges two things: that the output equals the previous line right after the load, and that the new line, once completed and loaded, matches its expected pixels on every column with no half-word slip.

// File: rtl/rsds_deser_pkg.sv
package rsds_deser_pkg;
  parameter int unsigned DEF_COLS   = 384;
  parameter int unsigned DEF_PIX_W  = 6;
  parameter int unsigned DEF_COLORS = 3;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } half_phase_e;
endpackage

// File: rtl/rsds_edge_sync.sv
module rsds_edge_sync #(
  parameter int unsigned CH = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dclk_i,
  input  logic [CH-1:0] data_i,
  input  logic          load_i,
  output logic          edge_o,
  output logic [CH-1:0] data_o,
  output logic          load_rise_o
);
  // two-stage capture, then one delay stage for edge detection
  logic          dclk_m, dclk_s, dclk_d;
  logic          load_m, load_s, load_d;
  logic [CH-1:0] data_m, data_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_m <= 1'b0;
      dclk_s <= 1'b0;
      dclk_d <= 1'b0;
      load_m <= 1'b0;
      load_s <= 1'b0;
      load_d <= 1'b0;
      data_m <= '0;
      data_s <= '0;
    end else begin
      dclk_m <= dclk_i;
      dclk_s <= dclk_m;
      dclk_d <= dclk_s;
      load_m <= load_i;
      load_s <= load_m;
      load_d <= load_s;
      data_m <= data_i;
      data_s <= data_m;
    end
  end

  assign edge_o      = dclk_s ^ dclk_d;
  assign load_rise_o = load_s & ~load_d;
  assign data_o      = data_s;
endmodule

// File: rtl/rsds_half_pair.sv
module rsds_half_pair
  import rsds_deser_pkg::*;
#(
  parameter int unsigned COLORS = 3,
  parameter int unsigned PIX_W  = 6,
  localparam int unsigned LANES = PIX_W / 2,
  localparam int unsigned CH    = COLORS * LANES,
  localparam int unsigned TW    = COLORS * PIX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic          load_rise_i,
  input  logic [CH-1:0] data_i,
  output logic          shift_o,
  output logic [TW-1:0] pix_o
);
  half_phase_e   phase_q;
  logic [CH-1:0] even_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_EVEN;
      even_q  <= '0;
    end else if (load_rise_i) begin
      // line start wins; a coincident edge is the new line's even half
      if (edge_i) begin
        even_q  <= data_i;
        phase_q <= PH_ODD;
      end else begin
        phase_q <= PH_EVEN;
      end
    end else if (edge_i) begin
      if (phase_q == PH_EVEN) begin
        even_q  <= data_i;
        phase_q <= PH_ODD;
      end else begin
        phase_q <= PH_EVEN;
      end
    end
  end

  assign shift_o = edge_i & ~load_rise_i & (phase_q == PH_ODD);

  // word = {o2,e2,o1,e1,o0,e0} per color
  for (genvar c = 0; c < COLORS; c++) begin : g_color
    for (genvar n = 0; n < LANES; n++) begin : g_lane
      assign pix_o[c*PIX_W + 2*n]     = even_q[c*LANES + n];
      assign pix_o[c*PIX_W + 2*n + 1] = data_i[c*LANES + n];
    end
  end

  assert_line_start_even_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (load_rise_i && !edge_i) |=> (phase_q == PH_EVEN && !shift_o));

  assert_coincident_even_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (load_rise_i && edge_i) |=> (phase_q == PH_ODD && even_q == $past(data_i)));
endmodule

// File: rtl/rsds_col_shift.sv
module rsds_col_shift #(
  parameter int unsigned TRIP = 128,
  parameter int unsigned TW   = 18,
  localparam int unsigned LW  = TRIP * TW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic [TW-1:0] pix_i,
  input  logic          load_i,
  output logic [LW-1:0] line_o
);
  logic [TW-1:0] sreg [TRIP];
  logic [TW-1:0] hold [TRIP];

  for (genvar k = 0; k < TRIP; k++) begin : g_slot
    logic [TW-1:0] next_val;
    if (k == TRIP - 1) begin : g_tail
      assign next_val = pix_i;
    end else begin : g_body
      assign next_val = sreg[k+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sreg[k] <= '0;
        hold[k] <= '0;
      end else begin
        if (shift_i) sreg[k] <= next_val;
        if (load_i)  hold[k] <= sreg[k];
      end
    end

    assign line_o[k*TW +: TW] = hold[k];
  end

  assert_hold_stable_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(line_o));

  assert_hold_capture_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hold[0] == $past(sreg[0]) && hold[TRIP-1] == $past(sreg[TRIP-1])));

  assert_shift_in_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sreg[TRIP-1] == $past(pix_i)));

  assert_shift_keep_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sreg[0]));
endmodule

// File: rtl/rsds_line_deser.sv
module rsds_line_deser
  import rsds_deser_pkg::*;
#(
  parameter int unsigned NUM_COLS   = DEF_COLS,
  parameter int unsigned PIX_W      = DEF_PIX_W,
  parameter int unsigned NUM_COLORS = DEF_COLORS,
  localparam int unsigned LANES  = PIX_W / 2,
  localparam int unsigned CH     = NUM_COLORS * LANES,
  localparam int unsigned TRIP   = NUM_COLS / NUM_COLORS,
  localparam int unsigned TW     = NUM_COLORS * PIX_W,
  localparam int unsigned LINE_W = NUM_COLS * PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dclk_i,
  input  logic [CH-1:0]     rsds_data_i,
  input  logic              line_load_i,
  output logic [LINE_W-1:0] line_o
);
  logic          edge_w;
  logic          load_rise_w;
  logic [CH-1:0] data_w;
  logic          shift_w;
  logic [TW-1:0] pix_w;

  rsds_edge_sync #(.CH(CH)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dclk_i      (dclk_i),
    .data_i      (rsds_data_i),
    .load_i      (line_load_i),
    .edge_o      (edge_w),
    .data_o      (data_w),
    .load_rise_o (load_rise_w)
  );

  rsds_half_pair #(.COLORS(NUM_COLORS), .PIX_W(PIX_W)) u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (edge_w),
    .load_rise_i (load_rise_w),
    .data_i      (data_w),
    .shift_o     (shift_w),
    .pix_o       (pix_w)
  );

  rsds_col_shift #(.TRIP(TRIP), .TW(TW)) u_cols (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_w),
    .pix_i   (pix_w),
    .load_i  (load_rise_w),
    .line_o  (line_o)
  );
endmodule

// File: tb/tb_rsds_line_deser.sv
module tb_rsds_line_deser;
  localparam int COLS = 384;
  localparam int TRIP = 128;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             dclk_i;
  logic [8:0]       rsds_data_i;
  logic             line_load_i;
  logic [COLS*6-1:0] line_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  rsds_line_deser dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dclk_i      (dclk_i),
    .rsds_data_i (rsds_data_i),
    .line_load_i (line_load_i),
    .line_o      (line_o)
  );

  function automatic logic [5:0] pix(int seed, int t, int c);
    return 6'((seed * 13 + t * 5 + c * 21 + (t >> 3)) & 63);
  endfunction

  // R2/R3: lane color*3+n carries bit 2n (even) or 2n+1 (odd)
  function automatic logic [8:0] half(int seed, int t, bit odd);
    logic [8:0] h;
    for (int c = 0; c < 3; c++)
      for (int n = 0; n < 3; n++)
        h[c*3+n] = pix(seed, t, c)[2*n + int'(odd)];
    return h;
  endfunction

  function automatic logic [5:0] col(int j);
    return line_o[(j-1)*6 +: 6];
  endfunction

  task automatic send_half(logic [8:0] h);
    @(negedge clk_i) rsds_data_i = h;
    @(negedge clk_i) dclk_i = ~dclk_i;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic send_line(int seed, int first, int count);
    for (int t = first; t < count; t++) begin
      send_half(half(seed, t, 1'b0));
      send_half(half(seed, t, 1'b1));
    end
  endtask

  task automatic pulse_load();
    @(negedge clk_i) line_load_i = 1'b1;
    repeat (4) @(negedge clk_i);
    line_load_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic check_line(string req, int seed, int off);
    int bad = 0;
    int bad_j = 0;
    logic [5:0] exp_v = '0;
    logic [5:0] got_v = '0;
    for (int j = 1; j <= COLS; j++) begin
      logic [5:0] e;
      e = pix(seed, (j-1)/3 + off, (j-1)%3);
      if (col(j) !== e) begin
        if (bad == 0) begin
          bad_j = j; exp_v = e; got_v = col(j);
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: line seed %0d col %0d actual %0h expected %0h (%0d bad cols)",
               req, seed, bad_j, got_v, exp_v, bad);
    end
  endtask

  task automatic check_val(string req, logic [5:0] act, logic [5:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (line_o !== '0) begin
      errors++;
      $display("FAIL R1: line after reset actual nonzero expected 0");
    end
  endtask

  task automatic t_basic();
    send_line(1, 0, TRIP);
    pulse_load();
    check_line("R2 R3 R4 R5", 1, 0);
    check_val("R5 col1 red first triplet", col(1), pix(1, 0, 0));
    check_val("R5 col384 blue last triplet", col(384), pix(1, TRIP-1, 2));
  endtask

  task automatic t_hold();
    send_line(2, 0, TRIP);
    check_line("R7 no load keeps line", 1, 0);
    @(negedge clk_i) line_load_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check_line("R7 rising edge loads", 2, 0);
    send_line(3, 0, TRIP);
    check_line("R7 load held high", 2, 0);
    line_load_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check_line("R7 load falling", 2, 0);
    pulse_load();
    check_line("R7 next rising edge", 3, 0);
  endtask

  task automatic t_dangling();
    send_half(half(9, 0, 1'b0));
    pulse_load();
    check_line("R8 unpaired half no shift", 3, 0);
    send_line(4, 0, TRIP);
    pulse_load();
    check_line("R8 pairing restarts", 4, 0);
  endtask

  task automatic t_overflow();
    send_line(5, 0, TRIP + 2);
    pulse_load();
    check_line("R6 oldest triplets dropped", 5, 2);
  endtask

  task automatic t_coincident();
    @(negedge clk_i) rsds_data_i = half(6, 0, 1'b0);
    @(negedge clk_i) begin
      dclk_i      = ~dclk_i;
      line_load_i = 1'b1;
    end
    repeat (4) @(negedge clk_i);
    check_line("R9 load captures previous line", 5, 2);
    line_load_i = 1'b0;
    repeat (2) @(negedge clk_i);
    send_half(half(6, 0, 1'b1));
    send_line(6, 1, TRIP);
    pulse_load();
    check_line("R9 coincident edge is even half", 6, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni      = 1'b0;
    dclk_i      = 1'b0;
    rsds_data_i = '0;
    line_load_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_basic();
    t_hold();
    t_dangling();
    t_overflow();
    t_coincident();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule